// File: doc/BRIEF.md
# Power-Save Clock-Gating Sequencer

This block tracks the run mode of a small processor system and, when software asks for it, puts the system into a power-save state by dropping clock-enable outputs. Entry happens on a wait-for-interrupt strobe. It also happens when the processor leaves its lowest-priority interrupt handler while the sleep-on-exit control bit is set. A two-bit sleep depth chooses how much is switched off. Each step deeper gates one more clock group: first the CPU clock, then the high-speed bus clocks, then the peripheral-bus and generic clocks, and finally the fast clock sources. The system RC clock is never gated. The 32 kHz sources keep whatever state they had just before entry.

Every interrupt request carries a two-bit tag that names the clock group its module runs from. A request can wake the system only while its group's enable is high. Wakeup turns the clocks back on in the reverse order of gating, one group per cycle, and then resumes the run mode that was active before entry. A reset always returns the system to the default run mode with the full run clock set enabled.

Top module: `pwr_save_ctrl`

## Requirements
- R1: After a synchronous reset, `mode_stat` is 0, `run_mode_out` is 0 and `depth_stat` is 0. `clk_en_cpu`, `clk_en_hsb`, `clk_en_pbg`, `clk_en_fast` and `clk_en_rcsys` are all 1, and `clk_en_32k` is 0.
- R2: In a run mode, a high `wfi` or a high `isr_exit` while `slpexit_en` is 1 causes entry, and `mode_stat` reads 2 (sleep) after the next clock edge. `isr_exit` while `slpexit_en` is 0 is ignored.
- R3: On entry with depth d, `clk_en_cpu` is 0, `clk_en_hsb` is 1 only for d=0, `clk_en_pbg` is 1 only for d<2, and `clk_en_fast` is 1 only for d<3.
- R4: `clk_en_rcsys` stays 1 at every depth. In a run mode `clk_en_32k` follows `osc32_on` one cycle later. From entry until the return to run it holds the value it had at entry.
- R5: During sleep, request i wakes the system only if the group named by its tag `irq_grp[2i+1:2i]` is enabled: tag 0 = system RC, 1 = high-speed bus, 2 = peripheral/generic, 3 = fast sources. Requests in gated groups are ignored.
- R6: The edge that takes a wake sets `clk_en_fast` and `mode_stat` to 3 (waking). The next edge sets `clk_en_pbg`, the one after sets `clk_en_hsb`, and the fourth sets `clk_en_cpu` and leaves the waking state.
- R7: After wakeup, `run_mode_out` equals its value before entry, and `mode_stat` is 0 for run mode 0 or 1 for any other run mode. `run_mode_wr` loads `run_mode_in` only in a run mode.
- R8: `depth_stat` reports the depth sampled at entry. `depth_wr` during sleep changes neither `depth_stat` nor the enables of the current sleep, and takes effect at the next entry.
- R9: A reset asserted during sleep returns the block to the R1 state, including run mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wfi | input | 1 | Wait-for-interrupt strobe |
| isr_exit | input | 1 | Exit from lowest-priority handler |
| slpexit_en | input | 1 | Sleep-on-exit control bit |
| depth_wr | input | 1 | Write strobe for the sleep depth register |
| depth_in | input | 2 | Sleep depth value to write |
| run_mode_wr | input | 1 | Write strobe for the run mode |
| run_mode_in | input | RUN_W | Run mode value to write |
| osc32_on | input | 1 | 32 kHz sources enabled by software |
| irq_req | input | N_IRQ | Interrupt requests |
| irq_grp | input | 2*N_IRQ | Clock-group tag per request |
| clk_en_cpu | output | 1 | CPU clock enable |
| clk_en_hsb | output | 1 | High-speed bus clock enable |
| clk_en_pbg | output | 1 | Peripheral-bus and generic clock enable |
| clk_en_fast | output | 1 | Fast clock source enable |
| clk_en_rcsys | output | 1 | System RC clock enable |
| clk_en_32k | output | 1 | 32 kHz source enable |
| mode_stat | output | 2 | 0 run mode 0, 1 other run mode, 2 sleep, 3 waking |
| run_mode_out | output | RUN_W | Current run mode |
| depth_stat | output | 2 | Depth latched at the last entry |

## Verification
The assertions assume the clock-group tags stay fixed while a request is pending. They also assume that entry strobes, depth writes and run-mode writes are single-cycle pulses driven only between clock edges. The stimulus drives every input one time unit after a rising edge and holds it for a full cycle. It raises one request line at a time, with a tag tied to that line, so each wake decision depends on a single group enable. Every depth is combined with every tag, so both accepted and rejected wakes are covered at each depth.

// File: rtl/pwr_save_pkg.sv
package pwr_save_pkg;
  localparam int GRP_W   = 2;
  localparam int DEPTH_W = 2;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_WAKE  = 2'd2
  } psc_state_e;

  localparam logic [1:0] MS_RUN0  = 2'd0;
  localparam logic [1:0] MS_RUNX  = 2'd1;
  localparam logic [1:0] MS_SLEEP = 2'd2;
  localparam logic [1:0] MS_WAKE  = 2'd3;

  localparam logic [1:0] LAST_STEP = 2'd3;
endpackage

// File: rtl/psc_mode_fsm.sv
module psc_mode_fsm
  import pwr_save_pkg::*;
#(
  parameter int RUN_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wfi,
  input  logic               isr_exit,
  input  logic               slpexit_en,
  input  logic               depth_wr,
  input  logic [DEPTH_W-1:0] depth_in,
  input  logic               run_mode_wr,
  input  logic [RUN_W-1:0]   run_mode_in,
  input  logic               wake,
  output psc_state_e         state,
  output logic [1:0]         step,
  output logic               enter,
  output logic [DEPTH_W-1:0] depth_reg,
  output logic [DEPTH_W-1:0] depth_lat,
  output logic [RUN_W-1:0]   run_mode_q
);

  assign enter = (state == ST_RUN) && (wfi || (isr_exit && slpexit_en));

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_RUN;
      step       <= '0;
      depth_reg  <= '0;
      depth_lat  <= '0;
      run_mode_q <= '0;
    end else begin
      if (depth_wr) depth_reg <= depth_in;
      unique case (state)
        ST_RUN: begin
          if (enter) begin
            state     <= ST_SLEEP;
            depth_lat <= depth_reg;
          end else if (run_mode_wr) begin
            run_mode_q <= run_mode_in;
          end
        end
        ST_SLEEP: begin
          if (wake) begin
            state <= ST_WAKE;
            step  <= 2'd1;
          end
        end
        ST_WAKE: begin
          if (step == LAST_STEP) begin
            state <= ST_RUN;
            step  <= '0;
          end else begin
            step <= step + 2'd1;
          end
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  AST_ENTER_SLEEP: assert property (@(posedge clk) disable iff (rst)
    enter |=> state == ST_SLEEP); // R2

  AST_DEPTH_HELD: assert property (@(posedge clk) disable iff (rst)
    (state != ST_RUN && $past(state) != ST_RUN) |-> $stable(depth_lat)); // R8

  AST_RUNMODE_HELD: assert property (@(posedge clk) disable iff (rst)
    (state != ST_RUN && $past(state) != ST_RUN) |-> $stable(run_mode_q)); // R7

  AST_WAKE_LEN: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAKE && step == LAST_STEP) |=> state == ST_RUN); // R6

endmodule

// File: rtl/psc_clk_gate.sv
module psc_clk_gate
  import pwr_save_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  psc_state_e         state,
  input  logic               enter,
  input  logic               wake,
  input  logic [1:0]         step,
  input  logic [DEPTH_W-1:0] depth_reg,
  input  logic [DEPTH_W-1:0] depth_lat,
  input  logic               osc32_on,
  output logic               en_cpu,
  output logic               en_hsb,
  output logic               en_pbg,
  output logic               en_fast,
  output logic               en_rcsys,
  output logic               en_32k
);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_cpu   <= 1'b1;
      en_hsb   <= 1'b1;
      en_pbg   <= 1'b1;
      en_fast  <= 1'b1;
      en_rcsys <= 1'b1;
      en_32k   <= 1'b0;
    end else begin
      en_rcsys <= 1'b1;
      if (enter) begin
        en_cpu  <= 1'b0;
        en_hsb  <= (depth_reg == 2'd0);
        en_pbg  <= (depth_reg < 2'd2);
        en_fast <= (depth_reg != 2'd3);
      end else if (wake) begin
        en_fast <= 1'b1;
      end else if (state == ST_WAKE) begin
        unique case (step)
          2'd1:    en_pbg <= 1'b1;
          2'd2:    en_hsb <= 1'b1;
          2'd3:    en_cpu <= 1'b1;
          default: en_fast <= 1'b1;
        endcase
      end
      if (state == ST_RUN && !enter) en_32k <= osc32_on;
    end
  end

  AST_CPU_GATED: assert property (@(posedge clk) disable iff (rst)
    state != ST_RUN |-> !en_cpu); // R3

  AST_DEEP_HSB: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SLEEP && depth_lat != 2'd0) |-> !en_hsb); // R3

  AST_WAKE_FAST_FIRST: assert property (@(posedge clk) disable iff (rst)
    state == ST_WAKE |-> en_fast); // R6

  AST_ORDER_CHAIN: assert property (@(posedge clk) disable iff (rst)
    (en_cpu |-> en_hsb) and (en_hsb |-> en_pbg) and (en_pbg |-> en_fast)); // R6

  AST_32K_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state != ST_RUN && $past(state) != ST_RUN) |-> $stable(en_32k)); // R4

endmodule

// File: rtl/psc_wake_qual.sv
module psc_wake_qual
  import pwr_save_pkg::*;
#(
  parameter int N_IRQ = 4
) (
  input  psc_state_e              state,
  input  logic [N_IRQ-1:0]        irq_req,
  input  logic [N_IRQ*GRP_W-1:0]  irq_grp,
  input  logic [3:0]              grp_on,
  output logic                    wake
);

  logic [N_IRQ-1:0] hit;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
    assign hit[i] = irq_req[i] && grp_on[irq_grp[i*GRP_W +: GRP_W]];
  end

  assign wake = (state == ST_SLEEP) && (|hit);

endmodule

// File: rtl/pwr_save_ctrl.sv
module pwr_save_ctrl
  import pwr_save_pkg::*;
#(
  parameter int N_IRQ = 4,
  parameter int RUN_W = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wfi,
  input  logic                   isr_exit,
  input  logic                   slpexit_en,
  input  logic                   depth_wr,
  input  logic [1:0]             depth_in,
  input  logic                   run_mode_wr,
  input  logic [RUN_W-1:0]       run_mode_in,
  input  logic                   osc32_on,
  input  logic [N_IRQ-1:0]       irq_req,
  input  logic [2*N_IRQ-1:0]     irq_grp,
  output logic                   clk_en_cpu,
  output logic                   clk_en_hsb,
  output logic                   clk_en_pbg,
  output logic                   clk_en_fast,
  output logic                   clk_en_rcsys,
  output logic                   clk_en_32k,
  output logic [1:0]             mode_stat,
  output logic [RUN_W-1:0]       run_mode_out,
  output logic [1:0]             depth_stat
);

  psc_state_e         state;
  logic [1:0]         step;
  logic               enter;
  logic               wake;
  logic [DEPTH_W-1:0] depth_reg;
  logic [DEPTH_W-1:0] depth_lat;
  logic [RUN_W-1:0]   run_mode_q;
  logic [3:0]         grp_on;

  psc_mode_fsm #(.RUN_W(RUN_W)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .wfi         (wfi),
    .isr_exit    (isr_exit),
    .slpexit_en  (slpexit_en),
    .depth_wr    (depth_wr),
    .depth_in    (depth_in),
    .run_mode_wr (run_mode_wr),
    .run_mode_in (run_mode_in),
    .wake        (wake),
    .state       (state),
    .step        (step),
    .enter       (enter),
    .depth_reg   (depth_reg),
    .depth_lat   (depth_lat),
    .run_mode_q  (run_mode_q)
  );

  psc_clk_gate u_gate (
    .clk       (clk),
    .rst       (rst),
    .state     (state),
    .enter     (enter),
    .wake      (wake),
    .step      (step),
    .depth_reg (depth_reg),
    .depth_lat (depth_lat),
    .osc32_on  (osc32_on),
    .en_cpu    (clk_en_cpu),
    .en_hsb    (clk_en_hsb),
    .en_pbg    (clk_en_pbg),
    .en_fast   (clk_en_fast),
    .en_rcsys  (clk_en_rcsys),
    .en_32k    (clk_en_32k)
  );

  // group index = tag: 0 system RC, 1 high-speed bus, 2 peripheral/generic, 3 fast sources
  assign grp_on = {clk_en_fast, clk_en_pbg, clk_en_hsb, clk_en_rcsys};

  psc_wake_qual #(.N_IRQ(N_IRQ)) u_qual (
    .state   (state),
    .irq_req (irq_req),
    .irq_grp (irq_grp),
    .grp_on  (grp_on),
    .wake    (wake)
  );

  always_comb begin
    unique case (state)
      ST_SLEEP: mode_stat = MS_SLEEP;
      ST_WAKE:  mode_stat = MS_WAKE;
      default:  mode_stat = (run_mode_q == '0) ? MS_RUN0 : MS_RUNX;
    endcase
  end

  assign run_mode_out = run_mode_q;
  assign depth_stat   = depth_lat;

  AST_GATED_NO_WAKE: assert property (@(posedge clk) disable iff (rst)
    (mode_stat == MS_SLEEP && (irq_req & ~{N_IRQ{1'b0}}) != '0 && !clk_en_hsb
     && !clk_en_pbg && !clk_en_fast && (irq_grp == {N_IRQ{2'd3}}))
    |=> mode_stat == MS_SLEEP); // R5

endmodule

// File: tb/pwr_save_ctrl_bench.sv
module pwr_save_ctrl_bench;
  localparam int N_IRQ = 4;
  localparam int RUN_W = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wfi = 1'b0, isr_exit = 1'b0, slpexit_en = 1'b0;
  logic depth_wr = 1'b0;
  logic [1:0] depth_in = '0;
  logic run_mode_wr = 1'b0;
  logic [RUN_W-1:0] run_mode_in = '0;
  logic osc32_on = 1'b0;
  logic [N_IRQ-1:0] irq_req = '0;
  logic [2*N_IRQ-1:0] irq_grp = {2'd3, 2'd2, 2'd1, 2'd0};
  logic en_cpu, en_hsb, en_pbg, en_fast, en_rcsys, en_32k;
  logic [1:0] mode_stat, depth_stat;
  logic [RUN_W-1:0] run_mode_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  pwr_save_ctrl #(.N_IRQ(N_IRQ), .RUN_W(RUN_W)) u_pwr_save_ctrl (
    .clk(clk), .rst(rst), .wfi(wfi), .isr_exit(isr_exit), .slpexit_en(slpexit_en),
    .depth_wr(depth_wr), .depth_in(depth_in), .run_mode_wr(run_mode_wr),
    .run_mode_in(run_mode_in), .osc32_on(osc32_on), .irq_req(irq_req), .irq_grp(irq_grp),
    .clk_en_cpu(en_cpu), .clk_en_hsb(en_hsb), .clk_en_pbg(en_pbg), .clk_en_fast(en_fast),
    .clk_en_rcsys(en_rcsys), .clk_en_32k(en_32k), .mode_stat(mode_stat),
    .run_mode_out(run_mode_out), .depth_stat(depth_stat)
  );

  // {depth, tag, expected wake}
  localparam logic [4:0] VEC [16] = '{
    {2'd0, 2'd0, 1'b1}, {2'd0, 2'd1, 1'b1}, {2'd0, 2'd2, 1'b1}, {2'd0, 2'd3, 1'b1},
    {2'd1, 2'd0, 1'b1}, {2'd1, 2'd1, 1'b0}, {2'd1, 2'd2, 1'b1}, {2'd1, 2'd3, 1'b1},
    {2'd2, 2'd0, 1'b1}, {2'd2, 2'd1, 1'b0}, {2'd2, 2'd2, 1'b0}, {2'd2, 2'd3, 1'b1},
    {2'd3, 2'd0, 1'b1}, {2'd3, 2'd1, 1'b0}, {2'd3, 2'd2, 1'b0}, {2'd3, 2'd3, 1'b0}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_depth(input logic [1:0] d);
    depth_in = d; depth_wr = 1'b1; tick(); depth_wr = 1'b0;
  endtask

  task automatic do_wfi();
    wfi = 1'b1; tick(); wfi = 1'b0;
  endtask

  task automatic pulse_irq(input int line);
    irq_req = '0; irq_req[line] = 1'b1; tick(); irq_req = '0;
  endtask

  task automatic finish_wake();
    tick(); tick(); tick();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst = 1'b0;
    // R1 reset state
    chk("R1 mode", mode_stat, 0);
    chk("R1 run mode", run_mode_out, 0);
    chk("R1 depth", depth_stat, 0);
    chk("R1 enables", {en_cpu, en_hsb, en_pbg, en_fast, en_rcsys, en_32k}, 6'b111110);

    // table walk: R3 R5 R6 R8
    for (int v = 0; v < 16; v++) begin
      automatic logic [1:0] d = VEC[v][4:3];
      automatic int tg = VEC[v][2:1];
      automatic logic ew = VEC[v][0];
      write_depth(d);
      do_wfi();
      chk("R2 enter", mode_stat, 2);
      chk("R8 depth latched", depth_stat, d);
      chk("R3 gating", {en_cpu, en_hsb, en_pbg, en_fast},
          {1'b0, d == 2'd0, d < 2'd2, d != 2'd3});
      chk("R4 rcsys", en_rcsys, 1);
      pulse_irq(tg);
      if (!ew) begin
        chk("R5 gated irq ignored", mode_stat, 2);
        chk("R5 enables unchanged", {en_hsb, en_pbg, en_fast},
            {d == 2'd0, d < 2'd2, d != 2'd3});
        pulse_irq(0);
      end
      chk("R6 step1 mode", mode_stat, 3);
      chk("R6 step1 enables", {en_cpu, en_hsb, en_pbg, en_fast},
          {1'b0, d == 2'd0, d < 2'd2, 1'b1});
      tick();
      chk("R6 step2 enables", {en_cpu, en_hsb, en_pbg, en_fast},
          {1'b0, d == 2'd0, 1'b1, 1'b1});
      tick();
      chk("R6 step3 enables", {en_cpu, en_hsb, en_pbg, en_fast}, 4'b0111);
      chk("R6 step3 mode", mode_stat, 3);
      tick();
      chk("R6 done enables", {en_cpu, en_hsb, en_pbg, en_fast}, 4'b1111);
      chk("R7 back to run0", mode_stat, 0);
    end

    // R2 sleep-on-exit
    write_depth(2'd0);
    isr_exit = 1'b1; tick(); isr_exit = 1'b0;
    chk("R2 isr_exit ignored without enable", mode_stat, 0);
    slpexit_en = 1'b1; isr_exit = 1'b1; tick(); isr_exit = 1'b0; slpexit_en = 1'b0;
    chk("R2 isr_exit entry", mode_stat, 2);
    pulse_irq(0); finish_wake();
    chk("R2 woke", mode_stat, 0);

    // R7 run mode kept across sleep
    run_mode_in = 2'd2; run_mode_wr = 1'b1; tick(); run_mode_wr = 1'b0;
    chk("R7 other run mode", mode_stat, 1);
    do_wfi();
    run_mode_in = 2'd3; run_mode_wr = 1'b1; tick(); run_mode_wr = 1'b0;
    chk("R7 write ignored in sleep", run_mode_out, 2);
    pulse_irq(0); finish_wake();
    chk("R7 mode restored", run_mode_out, 2);
    chk("R7 mode stat", mode_stat, 1);

    // R4 32 kHz hold
    osc32_on = 1'b1; tick();
    chk("R4 32k follows", en_32k, 1);
    do_wfi();
    osc32_on = 1'b0; tick(); tick();
    chk("R4 32k held in sleep", en_32k, 1);
    pulse_irq(0); finish_wake();
    chk("R4 32k held through wake", en_32k, 1);
    tick();
    chk("R4 32k follows after run", en_32k, 0);

    // R8 depth write during sleep
    write_depth(2'd1);
    do_wfi();
    write_depth(2'd3);
    chk("R8 depth_stat unchanged", depth_stat, 1);
    chk("R8 fast still on", en_fast, 1);
    pulse_irq(0); finish_wake();
    do_wfi();
    chk("R8 new depth next entry", depth_stat, 3);
    chk("R8 fast gated next entry", en_fast, 0);

    // R9 reset during sleep
    rst = 1'b1; tick(); rst = 1'b0;
    chk("R9 mode", mode_stat, 0);
    chk("R9 run mode", run_mode_out, 0);
    chk("R9 enables", {en_cpu, en_hsb, en_pbg, en_fast, en_rcsys, en_32k}, 6'b111110);
    chk("R9 depth", depth_stat, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule